// File: doc/BRIEF.md
# TDM Slot-Parity DMA Request Generator

This block sits between the serializers of a multichannel TDM audio port and a DMA controller. It watches per-serializer buffer-ready flags and raises single-cycle DMA request pulses, separately for the transmit side and the receive side. Each side has its own mode input. In combined mode, one request line serves every slot. In split mode, the request goes to an odd-slot line or an even-slot line, depending on the parity of the slot whose data the request moves.

A transmit request asks for the word that will be shifted out in the slot after the current one. A receive request asks the DMA to collect the word captured in the slot that has just ended. One request covers one word from every active serializer. A slot counter follows frame sync and slot boundary strobes. Buffer accesses clear ready flags, and serializer loads and captures set them. Underrun and overrun pulses mark a slot boundary that arrives while a buffer has not been serviced. DMA requests need no enable. Each side's interrupt line is gated by enable inputs.

Top module: `tdm_dma_req_gen`

## Requirements
- R1: A slot counter returns to slot 0 on the edge where `fsync_i` is high. Otherwise it advances by one on each `slot_strb_i` edge and wraps from NUM_SLOTS-1 to 0. Slot 0 is even. The counter is seen through the parity of the requests.
- R2: A transmit serializer's ready flag is set by `tx_load_i[n]` and cleared by `tx_wr_i[n]`. A receive serializer's ready flag is set by `rx_cap_i[n]` and cleared by `rx_rd_i[n]`. All flags are 0 after reset.
- R3: When the last active flag of a side becomes set, a request pulse of exactly one cycle follows one clock later. No further request comes until a flag has dropped and the set is complete again. A side with an all-zero active mask never requests.
- R4: With the mode input at 0 (combined), only `*_evt_o` pulses. With the mode input at 1 (split), only `*_evt_odd_o` or `*_evt_even_o` pulses. At most one of a side's three request outputs is high in any cycle.
- R5: A split transmit request's parity is that of the slot after the current one. After slot NUM_SLOTS-1 that slot is 0, which is even.
- R6: A split receive request's parity is that of the slot before the last boundary. This includes a boundary made by frame sync, where that slot is the last slot of the old frame.
- R7: The transmit mode and the receive mode are independent. Either side can be combined while the other is split.
- R8: If a set and a clear reach the same serializer in one cycle, the transmit flag ends cleared and the receive flag ends set.
- R9: `tx_urun_o` pulses for one cycle after a slot boundary (strobe or frame sync) at which any active transmit flag was set.
- R10: `rx_orun_o` pulses for one cycle after a slot boundary at which any active receive flag was set.
- R11: A side's interrupt output pulses with its request only when its ready-interrupt enable is 1. It pulses with its underrun or overrun only when the error-interrupt enable is 1. With both enables 0 it stays low.
- R12: The flags of serializers whose active bit is 0 take no part in requests, underrun or overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync_i | input | 1 | Frame sync, one cycle, starts slot 0 |
| slot_strb_i | input | 1 | Slot boundary strobe, one cycle |
| tx_split_i | input | 1 | Transmit request mode: 0 combined, 1 odd/even |
| rx_split_i | input | 1 | Receive request mode: 0 combined, 1 odd/even |
| tx_act_i | input | NUM_SER | Active transmit serializers |
| rx_act_i | input | NUM_SER | Active receive serializers |
| tx_load_i | input | NUM_SER | Serializer took its transmit buffer (sets flag) |
| rx_cap_i | input | NUM_SER | Serializer filled its receive buffer (sets flag) |
| tx_wr_i | input | NUM_SER | Write access to transmit buffer (clears flag) |
| rx_rd_i | input | NUM_SER | Read access to receive buffer (clears flag) |
| tx_rdy_ien_i | input | 1 | Interrupt enable for transmit requests |
| rx_rdy_ien_i | input | 1 | Interrupt enable for receive requests |
| tx_urun_ien_i | input | 1 | Interrupt enable for underrun |
| rx_orun_ien_i | input | 1 | Interrupt enable for overrun |
| tx_evt_o | output | 1 | Combined transmit DMA request |
| tx_evt_odd_o | output | 1 | Transmit DMA request, odd slot |
| tx_evt_even_o | output | 1 | Transmit DMA request, even slot |
| rx_evt_o | output | 1 | Combined receive DMA request |
| rx_evt_odd_o | output | 1 | Receive DMA request, odd slot |
| rx_evt_even_o | output | 1 | Receive DMA request, even slot |
| tx_urun_o | output | 1 | Transmit underrun pulse |
| rx_orun_o | output | 1 | Receive overrun pulse |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| rx_irq_o | output | 1 | Receive interrupt pulse |

## Verification
A buffer access and a serializer load or capture can hit the same serializer's flag in the same cycle. The two sides resolve this collision in opposite ways. The bench drives a full load together with a write to one transmit buffer, and a full capture together with a read of one receive buffer. It then judges the outcome by whether a request pulse follows: none on transmit, one on receive. A slot boundary that arrives together with new data is also provoked, in two forms. On transmit, a load lands with a strobe, and the next-slot parity must reflect the advanced counter. On receive, a capture lands with frame sync, and the parity must reflect the last slot of the old frame.

// File: rtl/tdm_dma_pkg.sv
// Package: shared types for the TDM DMA request generator.
// Assumes: nothing beyond IEEE 1800-2017.
package tdm_dma_pkg;

    // How a direction presents its DMA requests.
    typedef enum logic {
        REQ_COMBINED = 1'b0,
        REQ_SPLIT    = 1'b1
    } req_mode_e;

    // Collision priority for a ready-flag bank.
    typedef enum logic {
        PRIO_CLEAR = 1'b0,
        PRIO_SET   = 1'b1
    } flag_prio_e;

endpackage

// File: rtl/tdm_slot_tracker.sv
// Module: tdm_slot_tracker
// Counts TDM slots within a frame and keeps the slot index that was current
// before the most recent boundary. It gives the parity of the upcoming slot
// (for transmit look-ahead) and of the finished slot (for receive look-back).
// Assumes: fsync and strobe are single-cycle pulses; fsync wins over strobe.
module tdm_slot_tracker #(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync_i,
    input  logic              strobe_i,
    output logic [SLOT_W-1:0] cur_slot_o,
    output logic              next_odd_o,
    output logic              prev_odd_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0] cur_q;
    logic [SLOT_W-1:0] prev_q;
    logic [SLOT_W-1:0] next_slot;

    // Index of the slot that follows the current one, wrapping at frame end.
    always_comb begin
        if (cur_q == LAST_SLOT) next_slot = '0;
        else                    next_slot = cur_q + SLOT_W'(1);
    end

    // Current slot: frame sync restarts, a strobe advances.
    always_ff @(posedge clk) begin
        if (!rst_n)        cur_q <= '0;
        else if (fsync_i)  cur_q <= '0;
        else if (strobe_i) cur_q <= next_slot;
    end

    // Slot that just ended, captured at every boundary of either kind.
    always_ff @(posedge clk) begin
        if (!rst_n)                   prev_q <= '0;
        else if (fsync_i || strobe_i) prev_q <= cur_q;
    end

    assign cur_slot_o = cur_q;
    assign next_odd_o = next_slot[0];
    assign prev_odd_o = prev_q[0];

endmodule

// File: rtl/tdm_ready_bank.sv
// Module: tdm_ready_bank
// One ready flag per serializer. A serializer event sets a flag, and a buffer
// access clears it. PRIO picks the winner when both reach one bit in one cycle.
// Assumes: set and clear inputs are single-cycle strobes.
module tdm_ready_bank
    import tdm_dma_pkg::*;
#(
    parameter int         NUM_SER = 3,
    parameter flag_prio_e PRIO    = PRIO_CLEAR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SER-1:0] set_i,
    input  logic [NUM_SER-1:0] clr_i,
    output logic [NUM_SER-1:0] rdy_o
);
    logic [NUM_SER-1:0] rdy_q;

    for (genvar s = 0; s < NUM_SER; s++) begin : g_flag
        // Per-serializer flag update with the configured collision priority.
        always_ff @(posedge clk) begin
            if (!rst_n)                    rdy_q[s] <= 1'b0;
            else if (set_i[s] && clr_i[s]) rdy_q[s] <= (PRIO == PRIO_SET);
            else if (set_i[s])             rdy_q[s] <= 1'b1;
            else if (clr_i[s])             rdy_q[s] <= 1'b0;
        end
    end

    assign rdy_o = rdy_q;

endmodule

// File: rtl/tdm_evt_gen.sv
// Module: tdm_evt_gen
// Request and error logic for one direction. It detects when the last active
// flag becomes set and emits one request pulse routed by mode and parity. It
// flags a boundary that finds an unserviced active buffer, and forms the
// gated interrupt.
// Assumes: mode and active mask are held steady while traffic runs.
module tdm_evt_gen
    import tdm_dma_pkg::*;
#(
    parameter int NUM_SER = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SER-1:0] rdy_i,
    input  logic [NUM_SER-1:0] act_i,
    input  logic               split_i,
    input  logic               parity_odd_i,
    input  logic               boundary_i,
    input  logic               rdy_ien_i,
    input  logic               err_ien_i,
    output logic               evt_o,
    output logic               evt_odd_o,
    output logic               evt_even_o,
    output logic               err_o,
    output logic               irq_o
);
    logic      all_rdy;
    logic      all_rdy_q;
    logic      fire;
    logic      err_hit;
    logic      pulse_q;
    logic      odd_q;
    req_mode_e mode_q;
    logic      err_q;
    logic      irq_q;

    // Every active serializer is ready and at least one is active.
    assign all_rdy = (|act_i) && (&(rdy_i | ~act_i));
    assign fire    = all_rdy && !all_rdy_q;
    assign err_hit = boundary_i && (|(rdy_i & act_i));

    // Remember the previous completeness to detect its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) all_rdy_q <= 1'b0;
        else        all_rdy_q <= all_rdy;
    end

    // Register the request pulse with its mode and slot parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            odd_q   <= 1'b0;
            mode_q  <= REQ_COMBINED;
        end else begin
            pulse_q <= fire;
            odd_q   <= parity_odd_i;
            mode_q  <= req_mode_e'(split_i);
        end
    end

    // Register the boundary error pulse and the gated interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            err_q <= err_hit;
            irq_q <= (fire && rdy_ien_i) || (err_hit && err_ien_i);
        end
    end

    // Route the pulse to the combined line or to one parity line.
    always_comb begin
        evt_o      = 1'b0;
        evt_odd_o  = 1'b0;
        evt_even_o = 1'b0;
        if (mode_q == REQ_COMBINED) evt_o      = pulse_q;
        else if (odd_q)             evt_odd_o  = pulse_q;
        else                        evt_even_o = pulse_q;
    end

    assign err_o = err_q;
    assign irq_o = irq_q;

endmodule

// File: rtl/tdm_dma_req_gen.sv
// Module: tdm_dma_req_gen (top)
// DMA request generator for a TDM audio port. It has a shared slot tracker,
// one ready-flag bank per direction and one request generator per direction.
// Transmit requests carry the parity of the next slot. Receive requests carry
// the parity of the slot just finished.
// Assumes: strobes are single-cycle; frame sync also counts as a slot boundary.
module tdm_dma_req_gen
    import tdm_dma_pkg::*;
#(
    parameter int NUM_SER   = 3,
    parameter int NUM_SLOTS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fsync_i,
    input  logic               slot_strb_i,
    input  logic               tx_split_i,
    input  logic               rx_split_i,
    input  logic [NUM_SER-1:0] tx_act_i,
    input  logic [NUM_SER-1:0] rx_act_i,
    input  logic [NUM_SER-1:0] tx_load_i,
    input  logic [NUM_SER-1:0] rx_cap_i,
    input  logic [NUM_SER-1:0] tx_wr_i,
    input  logic [NUM_SER-1:0] rx_rd_i,
    input  logic               tx_rdy_ien_i,
    input  logic               rx_rdy_ien_i,
    input  logic               tx_urun_ien_i,
    input  logic               rx_orun_ien_i,
    output logic               tx_evt_o,
    output logic               tx_evt_odd_o,
    output logic               tx_evt_even_o,
    output logic               rx_evt_o,
    output logic               rx_evt_odd_o,
    output logic               rx_evt_even_o,
    output logic               tx_urun_o,
    output logic               rx_orun_o,
    output logic               tx_irq_o,
    output logic               rx_irq_o
);
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic [SLOT_W-1:0]  cur_slot;
    logic               next_odd;
    logic               prev_odd;
    logic               boundary;
    logic [NUM_SER-1:0] tx_rdy;
    logic [NUM_SER-1:0] rx_rdy;

    assign boundary = fsync_i || slot_strb_i;

    tdm_slot_tracker #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) slot_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync_i    (fsync_i),
        .strobe_i   (slot_strb_i),
        .cur_slot_o (cur_slot),
        .next_odd_o (next_odd),
        .prev_odd_o (prev_odd)
    );

    tdm_ready_bank #(
        .NUM_SER (NUM_SER),
        .PRIO    (PRIO_CLEAR)
    ) tx_bank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (tx_load_i),
        .clr_i (tx_wr_i),
        .rdy_o (tx_rdy)
    );

    tdm_ready_bank #(
        .NUM_SER (NUM_SER),
        .PRIO    (PRIO_SET)
    ) rx_bank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (rx_cap_i),
        .clr_i (rx_rd_i),
        .rdy_o (rx_rdy)
    );

    tdm_evt_gen #(
        .NUM_SER (NUM_SER)
    ) tx_gen_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rdy_i        (tx_rdy),
        .act_i        (tx_act_i),
        .split_i      (tx_split_i),
        .parity_odd_i (next_odd),
        .boundary_i   (boundary),
        .rdy_ien_i    (tx_rdy_ien_i),
        .err_ien_i    (tx_urun_ien_i),
        .evt_o        (tx_evt_o),
        .evt_odd_o    (tx_evt_odd_o),
        .evt_even_o   (tx_evt_even_o),
        .err_o        (tx_urun_o),
        .irq_o        (tx_irq_o)
    );

    tdm_evt_gen #(
        .NUM_SER (NUM_SER)
    ) rx_gen_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rdy_i        (rx_rdy),
        .act_i        (rx_act_i),
        .split_i      (rx_split_i),
        .parity_odd_i (prev_odd),
        .boundary_i   (boundary),
        .rdy_ien_i    (rx_rdy_ien_i),
        .err_ien_i    (rx_orun_ien_i),
        .evt_o        (rx_evt_o),
        .evt_odd_o    (rx_evt_odd_o),
        .evt_even_o   (rx_evt_even_o),
        .err_o        (rx_orun_o),
        .irq_o        (rx_irq_o)
    );

endmodule

// File: rtl/tdm_dma_req_chk.sv
// Module: tdm_dma_req_chk
// Assertion checker bound to tdm_dma_req_gen. It watches the ports, the flag
// banks and the slot counter.
// Assumes: active masks and enables are steady around the checked cycles.
module tdm_dma_req_chk #(
    parameter int NUM_SER   = 3,
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_W    = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fsync_i,
    input logic               slot_strb_i,
    input logic [SLOT_W-1:0]  cur_slot,
    input logic [NUM_SER-1:0] tx_rdy,
    input logic [NUM_SER-1:0] rx_rdy,
    input logic [NUM_SER-1:0] tx_act_i,
    input logic [NUM_SER-1:0] rx_act_i,
    input logic               tx_rdy_ien_i,
    input logic               rx_rdy_ien_i,
    input logic               tx_urun_ien_i,
    input logic               rx_orun_ien_i,
    input logic               tx_evt_o,
    input logic               tx_evt_odd_o,
    input logic               tx_evt_even_o,
    input logic               rx_evt_o,
    input logic               rx_evt_odd_o,
    input logic               rx_evt_even_o,
    input logic               tx_urun_o,
    input logic               rx_orun_o,
    input logic               tx_irq_o,
    input logic               rx_irq_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic tx_any;
    logic rx_any;
    assign tx_any = tx_evt_o || tx_evt_odd_o || tx_evt_even_o;
    assign rx_any = rx_evt_o || rx_evt_odd_o || rx_evt_even_o;

    p_slot_fsync_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_i |=> (cur_slot == '0));

    p_slot_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_strb_i && !fsync_i && cur_slot == LAST_SLOT) |=> (cur_slot == '0));

    p_tx_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_any |=> !tx_any);

    p_rx_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_any |=> !rx_any);

    p_tx_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_any |-> $past((|tx_act_i) && (&(tx_rdy | ~tx_act_i))));

    p_rx_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_any |-> $past((|rx_act_i) && (&(rx_rdy | ~rx_act_i))));

    p_tx_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_evt_o, tx_evt_odd_o, tx_evt_even_o}));

    p_rx_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_evt_o, rx_evt_odd_o, rx_evt_even_o}));

    p_urun_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsync_i || slot_strb_i) && (|(tx_rdy & tx_act_i))) |=> tx_urun_o);

    p_urun_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !((fsync_i || slot_strb_i) && (|(tx_rdy & tx_act_i))) |=> !tx_urun_o);

    p_orun_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsync_i || slot_strb_i) && (|(rx_rdy & rx_act_i))) |=> rx_orun_o);

    p_orun_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !((fsync_i || slot_strb_i) && (|(rx_rdy & rx_act_i))) |=> !rx_orun_o);

    p_tx_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_rdy_ien_i && !tx_urun_ien_i) |=> !tx_irq_o);

    p_rx_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_rdy_ien_i && !rx_orun_ien_i) |=> !rx_irq_o);

endmodule

bind tdm_dma_req_gen tdm_dma_req_chk #(
    .NUM_SER   (NUM_SER),
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fsync_i       (fsync_i),
    .slot_strb_i   (slot_strb_i),
    .cur_slot      (cur_slot),
    .tx_rdy        (tx_rdy),
    .rx_rdy        (rx_rdy),
    .tx_act_i      (tx_act_i),
    .rx_act_i      (rx_act_i),
    .tx_rdy_ien_i  (tx_rdy_ien_i),
    .rx_rdy_ien_i  (rx_rdy_ien_i),
    .tx_urun_ien_i (tx_urun_ien_i),
    .rx_orun_ien_i (rx_orun_ien_i),
    .tx_evt_o      (tx_evt_o),
    .tx_evt_odd_o  (tx_evt_odd_o),
    .tx_evt_even_o (tx_evt_even_o),
    .rx_evt_o      (rx_evt_o),
    .rx_evt_odd_o  (rx_evt_odd_o),
    .rx_evt_even_o (rx_evt_even_o),
    .tx_urun_o     (tx_urun_o),
    .rx_orun_o     (rx_orun_o),
    .tx_irq_o      (tx_irq_o),
    .rx_irq_o      (rx_irq_o)
);

// File: tb/tdm_dma_req_gen_tb.sv
`timescale 1ns/1ps
// Directed bench for tdm_dma_req_gen: one task per scenario, each self-checking.
module tdm_dma_req_gen_tb_top;
    localparam int NS = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fsync = 1'b0, strb = 1'b0;
    logic          tx_split = 1'b0, rx_split = 1'b0;
    logic [NS-1:0] tx_act = '0, rx_act = '0;
    logic [NS-1:0] tx_load = '0, rx_cap = '0, tx_wr = '0, rx_rd = '0;
    logic          tx_rien = 1'b0, rx_rien = 1'b0, tx_uien = 1'b0, rx_oien = 1'b0;
    logic          tx_evt, tx_odd, tx_even, rx_evt, rx_odd, rx_even;
    logic          tx_urun, rx_orun, tx_irq, rx_irq;
    int            n_cmp = 0;
    int            n_bad = 0;

    always #2.5 clk = ~clk;

    tdm_dma_req_gen #(.NUM_SER(NS), .NUM_SLOTS(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .slot_strb_i(strb),
        .tx_split_i(tx_split), .rx_split_i(rx_split),
        .tx_act_i(tx_act), .rx_act_i(rx_act),
        .tx_load_i(tx_load), .rx_cap_i(rx_cap), .tx_wr_i(tx_wr), .rx_rd_i(rx_rd),
        .tx_rdy_ien_i(tx_rien), .rx_rdy_ien_i(rx_rien),
        .tx_urun_ien_i(tx_uien), .rx_orun_ien_i(rx_oien),
        .tx_evt_o(tx_evt), .tx_evt_odd_o(tx_odd), .tx_evt_even_o(tx_even),
        .rx_evt_o(rx_evt), .rx_evt_odd_o(rx_odd), .rx_evt_even_o(rx_even),
        .tx_urun_o(tx_urun), .rx_orun_o(rx_orun), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
    );

    task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fsync = 0; strb = 0; tx_split = 0; rx_split = 0;
        tx_act = '0; rx_act = '0; tx_load = '0; rx_cap = '0; tx_wr = '0; rx_rd = '0;
        tx_rien = 0; rx_rien = 0; tx_uien = 0; rx_oien = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drive one cycle of strobes, then return just after that clock edge.
    task automatic drive(input logic [NS-1:0] tl, input logic [NS-1:0] rc,
                         input logic [NS-1:0] tw, input logic [NS-1:0] rr,
                         input logic stb, input logic fs);
        tx_load = tl; rx_cap = rc; tx_wr = tw; rx_rd = rr; strb = stb; fsync = fs;
        @(negedge clk);
        tx_load = '0; rx_cap = '0; tx_wr = '0; rx_rd = '0; strb = 0; fsync = 0;
    endtask

    // Request appears one edge after the flags settle, then must drop (R3).
    task automatic expect_evt(input string req, input logic [2:0] etx, input logic [2:0] erx);
        @(negedge clk);
        chk(req, "tx req {comb,odd,even}", {1'b0, tx_evt, tx_odd, tx_even}, {1'b0, etx});
        chk(req, "rx req {comb,odd,even}", {1'b0, rx_evt, rx_odd, rx_even}, {1'b0, erx});
        @(negedge clk);
        chk("R3", "request one cycle", {2'b0, tx_evt | tx_odd | tx_even, rx_evt | rx_odd | rx_even}, 4'h0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R2", "outputs after reset",
            {tx_evt | tx_odd | tx_even, rx_evt | rx_odd | rx_even, tx_urun | rx_orun, tx_irq | rx_irq}, 4'h0);
    endtask

    task automatic t_tx_combined();
        do_reset(); tx_act = 3'b111;
        drive(3'b011, '0, '0, '0, 0, 0);
        expect_evt("R3", 3'b000, 3'b000);
        drive(3'b100, '0, '0, '0, 0, 0);
        expect_evt("R3", 3'b100, 3'b000);
        drive('0, '0, '0, '0, 0, 0);
        expect_evt("R3", 3'b000, 3'b000);
        drive('0, '0, 3'b010, '0, 0, 0);
        drive(3'b010, '0, '0, '0, 0, 0);
        expect_evt("R2", 3'b100, 3'b000);
    endtask

    task automatic t_tx_parity();
        do_reset(); tx_act = 3'b111; tx_split = 1;
        drive(3'b111, '0, '0, '0, 0, 0);
        expect_evt("R5", 3'b010, 3'b000);
        drive('0, '0, 3'b111, '0, 0, 0);
        drive(3'b111, '0, '0, '0, 1, 0);
        expect_evt("R5", 3'b001, 3'b000);
        drive('0, '0, 3'b111, '0, 0, 0);
        for (int i = 0; i < 5; i++) drive('0, '0, '0, '0, 1, 0);
        drive(3'b111, '0, '0, '0, 0, 0);
        expect_evt("R5", 3'b010, 3'b000);
        drive('0, '0, 3'b111, '0, 0, 0);
        drive('0, '0, '0, '0, 1, 0);
        drive(3'b111, '0, '0, '0, 0, 0);
        expect_evt("R1", 3'b001, 3'b000);
        drive('0, '0, 3'b111, '0, 0, 0);
        drive('0, '0, '0, '0, 0, 1);
        drive(3'b111, '0, '0, '0, 0, 0);
        expect_evt("R1", 3'b010, 3'b000);
    endtask

    task automatic t_rx_parity();
        do_reset(); rx_act = 3'b111; rx_split = 1;
        drive('0, 3'b111, '0, '0, 1, 0);
        expect_evt("R6", 3'b000, 3'b001);
        drive('0, '0, '0, 3'b111, 0, 0);
        drive('0, 3'b111, '0, '0, 1, 0);
        expect_evt("R6", 3'b000, 3'b010);
        drive('0, '0, '0, 3'b111, 0, 0);
        drive('0, '0, '0, '0, 1, 0);
        drive('0, 3'b111, '0, '0, 0, 1);
        expect_evt("R6", 3'b000, 3'b010);
    endtask

    task automatic t_independent();
        do_reset(); tx_act = 3'b111; rx_act = 3'b111; tx_split = 0; rx_split = 1;
        drive(3'b111, 3'b111, '0, '0, 0, 0);
        expect_evt("R7", 3'b100, 3'b001);
        do_reset(); tx_act = 3'b111; rx_act = 3'b111; tx_split = 1; rx_split = 0;
        drive(3'b111, 3'b111, '0, '0, 0, 0);
        expect_evt("R4", 3'b010, 3'b100);
    endtask

    task automatic t_inactive();
        do_reset(); tx_act = 3'b101;
        drive(3'b010, '0, '0, '0, 0, 0);
        expect_evt("R12", 3'b000, 3'b000);
        drive(3'b101, '0, '0, '0, 0, 0);
        expect_evt("R12", 3'b100, 3'b000);
        drive('0, '0, 3'b101, '0, 0, 0);
        drive('0, '0, '0, '0, 1, 0);
        chk("R12", "no underrun from idle serializer", {3'b0, tx_urun}, 4'h0);
        do_reset(); tx_act = 3'b000;
        drive(3'b111, '0, '0, '0, 0, 0);
        expect_evt("R3", 3'b000, 3'b000);
    endtask

    task automatic t_collide();
        do_reset(); tx_act = 3'b111;
        drive(3'b111, '0, 3'b001, '0, 0, 0);
        expect_evt("R8", 3'b000, 3'b000);
        drive(3'b001, '0, '0, '0, 0, 0);
        expect_evt("R8", 3'b100, 3'b000);
        do_reset(); rx_act = 3'b111;
        drive('0, 3'b111, '0, 3'b001, 0, 0);
        expect_evt("R8", 3'b000, 3'b100);
    endtask

    task automatic t_underrun();
        do_reset(); tx_act = 3'b111;
        drive(3'b111, '0, '0, '0, 0, 0);
        expect_evt("R9", 3'b100, 3'b000);
        drive('0, '0, '0, '0, 1, 0);
        chk("R9", "underrun {urun,irq}", {2'b0, tx_urun, tx_irq}, 4'h2);
        @(negedge clk);
        chk("R9", "underrun drops", {3'b0, tx_urun}, 4'h0);
        tx_uien = 1;
        drive('0, '0, '0, '0, 1, 0);
        chk("R11", "underrun irq enabled", {2'b0, tx_urun, tx_irq}, 4'h3);
        drive('0, '0, 3'b111, '0, 0, 0);
        drive('0, '0, '0, '0, 1, 0);
        chk("R9", "serviced boundary", {2'b0, tx_urun, tx_irq}, 4'h0);
    endtask

    task automatic t_overrun();
        do_reset(); rx_act = 3'b111;
        drive('0, 3'b111, '0, '0, 0, 0);
        expect_evt("R10", 3'b000, 3'b100);
        drive('0, '0, '0, '0, 1, 0);
        chk("R10", "overrun {orun,irq}", {2'b0, rx_orun, rx_irq}, 4'h2);
        rx_oien = 1;
        drive('0, '0, '0, '0, 1, 0);
        chk("R11", "overrun irq enabled", {2'b0, rx_orun, rx_irq}, 4'h3);
        drive('0, '0, '0, 3'b111, 0, 0);
        drive('0, '0, '0, '0, 1, 0);
        chk("R10", "read before boundary", {2'b0, rx_orun, rx_irq}, 4'h0);
    endtask

    task automatic t_irq();
        do_reset(); tx_act = 3'b111; rx_act = 3'b111;
        drive(3'b111, 3'b111, '0, '0, 0, 0);
        @(negedge clk);
        chk("R11", "req with irq disabled {txe,txi,rxe,rxi}", {tx_evt, tx_irq, rx_evt, rx_irq}, 4'hA);
        do_reset(); tx_act = 3'b111; rx_act = 3'b111; tx_rien = 1; rx_rien = 1;
        drive(3'b111, 3'b111, '0, '0, 0, 0);
        @(negedge clk);
        chk("R11", "req with irq enabled {txe,txi,rxe,rxi}", {tx_evt, tx_irq, rx_evt, rx_irq}, 4'hF);
        @(negedge clk);
        chk("R11", "irq one cycle", {2'b0, tx_irq, rx_irq}, 4'h0);
    endtask

    initial begin
        t_reset();
        t_tx_combined();
        t_tx_parity();
        t_rx_parity();
        t_independent();
        t_inactive();
        t_collide();
        t_underrun();
        t_overrun();
        t_irq();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule